// File: doc/BRIEF.md
# CAN Transmit Buffer Abort Controller

This block keeps the per-buffer state of a small group of CAN transmit buffers (three by default): an empty flag, a sticky abort request, an abort acknowledge flag and an empty-interrupt enable. Software claims a buffer by clearing its empty flag. It can then ask for that pending message to be withdrawn. Software also chooses which buffers may interrupt when they become free again.

A transmitter engine reports two events. The first is the start of a transmission from a given buffer. The second is the end of that attempt, together with a success or failure indication. The block decides when a withdrawal is honoured. It does so only while the buffer is not being sent, or at the end of an attempt that failed. It then updates the flags and drives a single interrupt line. A soft-reset input clears the control register and holds it at zero.

Top module: `txab_ctrl`

## Requirements
- R1: After `rst_n` is released, `empty_o` is all ones, `ack_o` is all zeros, `ctl_rdata` is 0 and `irq_o` is 0.
- R2: A flag write with bit i of `flag_wdata` at 1, while buffer i is empty, clears both `empty_o[i]` and `ack_o[i]` on the next cycle. A 1 for a buffer that is not empty is ignored.
- R3: The control register is 8 bits wide. Bits 6, 5 and 4 are the abort requests of buffers 2, 1 and 0. Bits 2, 1 and 0 are the interrupt enables of buffers 2, 1 and 0. Bits 7 and 3 always read 0. A control write loads the enables directly.
- R4: A 1 written to an abort bit is taken only while that buffer is not empty, and is ignored otherwise. Writing 0 never clears a pending request. A request bit reads 0 whenever its buffer is empty.
- R5: A pending request on a buffer that is not in flight is granted on the next clock edge. The grant sets `empty_o[i]` and `ack_o[i]` and clears the request.
- R6: A start for buffer i is ignored if the buffer is empty, already in flight, or has a request pending. A later done for that buffer then has no effect.
- R7: A done with `done_ok`=1 for an in-flight buffer sets its empty flag, clears its request and leaves its acknowledge flag at 0.
- R8: A failed done with no request pending leaves the buffer scheduled and not in flight, so a new start is accepted.
- R9: A request made while the buffer is in flight waits for the outcome. On a failed done it is granted, which sets the empty and acknowledge flags.
- R10: `irq_o` is 1 exactly when some buffer has both its empty flag and its enable at 1.
- R11: While `soft_rst` is 1, the control register reads 0 from the next cycle on and ignores writes. The empty and acknowledge flags keep working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Forces and holds the control register at zero |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| flag_wr | input | 1 | Empty-flag write strobe (a 1 schedules that buffer) |
| flag_wdata | input | NBUF | Per-buffer schedule bits |
| empty_o | output | NBUF | Per-buffer empty flags |
| ack_o | output | NBUF | Per-buffer abort acknowledge flags |
| tx_start | input | 1 | Engine begins sending a buffer |
| tx_start_idx | input | IDXW | Buffer being started |
| tx_done | input | 1 | Engine ends an attempt |
| tx_done_idx | input | IDXW | Buffer whose attempt ended |
| tx_done_ok | input | 1 | 1 = success, 0 = lost arbitration or error |
| irq_o | output | 1 | Transmit-empty interrupt |

## Verification
The hardest case to reach is a request that arrives while the buffer is in flight. That request must wait, survive a write of 0, and then be granted by a failed done instead of by the idle-grant path. The directed stimulus schedules two buffers and starts both. It then posts the request mid-flight, attempts a clearing write, and ends one buffer with a failure and the other with a success. A further sequence raises a start in the same cycle as an idle grant, then sends a done for that buffer to show the start was never taken. A long random phase follows, checked on every cycle against a behavioural model.

// File: rtl/txab_pkg.sv
package txab_pkg;
   localparam int REG_W   = 8;
   localparam int ABT_LSB = 4;
   localparam int IE_LSB  = 0;
   localparam int MAX_BUF = 3;
endpackage

// File: rtl/txab_slot.sv
module txab_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic sched_i,
   input  logic abt_set_i,
   input  logic ie_wr_i,
   input  logic ie_d_i,
   input  logic start_i,
   input  logic done_i,
   input  logic ok_i,
   output logic empty_o,
   output logic ack_o,
   output logic abt_o,
   output logic ie_o,
   output logic busy_o
);
   logic empty_q, ack_q, abt_q, ie_q, busy_q;
   logic fin_ok, fin_ab, grant, set_e, take_sched, take_start;

   assign fin_ok     = done_i & busy_q & ok_i;
   assign fin_ab     = done_i & busy_q & ~ok_i & abt_q;
   assign grant      = ~busy_q & abt_q;
   assign set_e      = fin_ok | fin_ab | grant;
   assign take_sched = sched_i & empty_q;
   assign take_start = start_i & ~empty_q & ~abt_q & ~busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         ack_q   <= 1'b0;
         abt_q   <= 1'b0;
         ie_q    <= 1'b0;
         busy_q  <= 1'b0;
      end else begin
         if (done_i && busy_q)
            busy_q <= 1'b0;
         else if (take_start)
            busy_q <= 1'b1;

         if (set_e) begin
            empty_q <= 1'b1;
            ack_q   <= fin_ab | grant;
         end else if (take_sched) begin
            empty_q <= 1'b0;
            ack_q   <= 1'b0;
         end

         if (soft_rst || set_e)
            abt_q <= 1'b0;
         else if (abt_set_i && !empty_q)
            abt_q <= 1'b1;

         if (soft_rst)
            ie_q <= 1'b0;
         else if (ie_wr_i)
            ie_q <= ie_d_i;
      end
   end

   assign empty_o = empty_q;
   assign ack_o   = ack_q;
   assign abt_o   = abt_q;
   assign ie_o    = ie_q;
   assign busy_o  = busy_q;
endmodule

// File: rtl/txab_ctlmap.sv
module txab_ctlmap
   import txab_pkg::*;
#(
   parameter int NBUF = 3
) (
   input  logic             wr_i,
   input  logic [REG_W-1:0] wdata_i,
   input  logic [NBUF-1:0]  abt_i,
   input  logic [NBUF-1:0]  ie_i,
   output logic [NBUF-1:0]  abt_set_o,
   output logic             ie_wr_o,
   output logic [NBUF-1:0]  ie_d_o,
   output logic [REG_W-1:0] rdata_o
);
   assign ie_wr_o = wr_i;

   always_comb begin
      rdata_o = '0;
      for (int b = 0; b < NBUF; b++) begin
         rdata_o[ABT_LSB + b] = abt_i[b];
         rdata_o[IE_LSB + b]  = ie_i[b];
      end
   end

   for (genvar g = 0; g < NBUF; g++) begin : g_dec
      assign abt_set_o[g] = wr_i & wdata_i[ABT_LSB + g];
      assign ie_d_o[g]    = wdata_i[IE_LSB + g];
   end
endmodule

// File: rtl/txab_irq.sv
module txab_irq #(
   parameter int NBUF = 3
) (
   input  logic [NBUF-1:0] empty_i,
   input  logic [NBUF-1:0] ie_i,
   output logic            irq_o
);
   assign irq_o = |(empty_i & ie_i);
endmodule

// File: rtl/txab_ctrl.sv
module txab_ctrl
   import txab_pkg::*;
#(
   parameter int NBUF = 3,
   localparam int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             ctl_wr,
   input  logic [REG_W-1:0] ctl_wdata,
   output logic [REG_W-1:0] ctl_rdata,
   input  logic             flag_wr,
   input  logic [NBUF-1:0]  flag_wdata,
   output logic [NBUF-1:0]  empty_o,
   output logic [NBUF-1:0]  ack_o,
   input  logic             tx_start,
   input  logic [IDXW-1:0]  tx_start_idx,
   input  logic             tx_done,
   input  logic [IDXW-1:0]  tx_done_idx,
   input  logic             tx_done_ok,
   output logic             irq_o
);
   if (NBUF < 1 || NBUF > MAX_BUF) begin : g_bad_nbuf
      $error("txab_ctrl: NBUF must lie in 1..%0d", MAX_BUF);
   end

   logic [NBUF-1:0] abt_w, ie_w, busy_w, abt_set_w, ie_d_w;
   logic            ie_wr_w;

   txab_ctlmap #(.NBUF(NBUF)) u_map (
      .wr_i      (ctl_wr),
      .wdata_i   (ctl_wdata),
      .abt_i     (abt_w),
      .ie_i      (ie_w),
      .abt_set_o (abt_set_w),
      .ie_wr_o   (ie_wr_w),
      .ie_d_o    (ie_d_w),
      .rdata_o   (ctl_rdata)
   );

   for (genvar g = 0; g < NBUF; g++) begin : g_slot
      txab_slot u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .soft_rst  (soft_rst),
         .sched_i   (flag_wr & flag_wdata[g]),
         .abt_set_i (abt_set_w[g]),
         .ie_wr_i   (ie_wr_w),
         .ie_d_i    (ie_d_w[g]),
         .start_i   (tx_start & (tx_start_idx == IDXW'(g))),
         .done_i    (tx_done & (tx_done_idx == IDXW'(g))),
         .ok_i      (tx_done_ok),
         .empty_o   (empty_o[g]),
         .ack_o     (ack_o[g]),
         .abt_o     (abt_w[g]),
         .ie_o      (ie_w[g]),
         .busy_o    (busy_w[g])
      );
   end

   txab_irq #(.NBUF(NBUF)) u_irq (
      .empty_i (empty_o),
      .ie_i    (ie_w),
      .irq_o   (irq_o)
   );
endmodule

// File: rtl/txab_chk.sv
module txab_chk
   import txab_pkg::*;
#(
   parameter int NBUF = 3,
   localparam int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst,
   input logic [REG_W-1:0] ctl_rdata,
   input logic [NBUF-1:0]  empty_o,
   input logic [NBUF-1:0]  ack_o,
   input logic [NBUF-1:0]  busy_w,
   input logic             tx_done,
   input logic [IDXW-1:0]  tx_done_idx,
   input logic             tx_done_ok,
   input logic             irq_o
);
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[7] == 1'b0) && (ctl_rdata[3] == 1'b0)); // R3

   AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ctl_rdata == '0)); // R11

   AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == |(empty_o & ctl_rdata[IE_LSB +: NBUF])); // R10

   for (genvar g = 0; g < NBUF; g++) begin : g_buf
      AST_ACK_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
         ack_o[g] |-> empty_o[g]); // R5

      AST_REQ_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
         ctl_rdata[ABT_LSB + g] |-> !empty_o[g]); // R4

      AST_OK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_done && tx_done_ok && busy_w[g] && (tx_done_idx == IDXW'(g)))
         |=> (empty_o[g] && !ack_o[g])); // R7

      AST_FAIL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_done && !tx_done_ok && busy_w[g] && (tx_done_idx == IDXW'(g))
          && ctl_rdata[ABT_LSB + g]) |=> (empty_o[g] && ack_o[g])); // R9
   end
endmodule

bind txab_ctrl txab_chk #(.NBUF(NBUF)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .soft_rst    (soft_rst),
   .ctl_rdata   (ctl_rdata),
   .empty_o     (empty_o),
   .ack_o       (ack_o),
   .busy_w      (busy_w),
   .tx_done     (tx_done),
   .tx_done_idx (tx_done_idx),
   .tx_done_ok  (tx_done_ok),
   .irq_o       (irq_o)
);

// File: tb/sim_txab_ctrl.sv
`timescale 1ns/1ps
module sim_txab_ctrl;
   localparam int NB = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic [7:0] ctl_rdata;
   logic       flag_wr = 1'b0;
   logic [2:0] flag_wdata = '0;
   logic [2:0] empty_o, ack_o;
   logic       tx_start = 1'b0;
   logic [1:0] tx_start_idx = '0;
   logic       tx_done = 1'b0;
   logic [1:0] tx_done_idx = '0;
   logic       tx_done_ok = 1'b0;
   logic       irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done_flag = 0;

   always #10 clk = ~clk;

   txab_ctrl #(.NBUF(NB)) u0 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .flag_wr(flag_wr), .flag_wdata(flag_wdata),
      .empty_o(empty_o), .ack_o(ack_o),
      .tx_start(tx_start), .tx_start_idx(tx_start_idx),
      .tx_done(tx_done), .tx_done_idx(tx_done_idx), .tx_done_ok(tx_done_ok),
      .irq_o(irq_o)
   );

   // behavioural reference
   bit m_e[NB], m_a[NB], m_r[NB], m_ie[NB], m_f[NB];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NB; i++) begin
            m_e[i] = 1; m_a[i] = 0; m_r[i] = 0; m_ie[i] = 0; m_f[i] = 0;
         end
      end else begin
         for (int i = 0; i < NB; i++) begin
            bit se, sa, nr, ne, na, nie;
            se = 0; sa = 0;
            if (tx_done && tx_done_idx == i && m_f[i]) begin
               m_f[i] = 0;
               if (tx_done_ok) se = 1;
               else if (m_r[i]) begin se = 1; sa = 1; end
            end else if (!m_f[i] && m_r[i]) begin
               se = 1; sa = 1;
            end else if (tx_start && tx_start_idx == i && !m_e[i]) begin
               m_f[i] = 1;
            end
            if (soft_rst || se) nr = 0;
            else nr = m_r[i] | (ctl_wr & ctl_wdata[4+i] & !m_e[i]);
            if (se) begin ne = 1; na = sa; end
            else if (flag_wr && flag_wdata[i] && m_e[i]) begin ne = 0; na = 0; end
            else begin ne = m_e[i]; na = m_a[i]; end
            nie = soft_rst ? 1'b0 : (ctl_wr ? ctl_wdata[i] : m_ie[i]);
            m_r[i] = nr; m_e[i] = ne; m_a[i] = na; m_ie[i] = nie;
         end
      end
   end

   function automatic logic [7:0] m_ctl();
      logic [7:0] v = '0;
      for (int i = 0; i < NB; i++) begin
         v[4+i] = m_r[i];
         v[i]   = m_ie[i];
      end
      return v;
   endfunction

   function automatic logic [2:0] m_vec(input int sel);
      logic [2:0] v;
      for (int i = 0; i < NB; i++) v[i] = (sel == 0) ? m_e[i] : m_a[i];
      return v;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle model comparison
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         logic mi;
         mi = 0;
         for (int i = 0; i < NB; i++) mi |= m_e[i] & m_ie[i];
         check("R5 empty flags vs model", {5'b0, empty_o}, {5'b0, m_vec(0)});
         check("R9 ack flags vs model", {5'b0, ack_o}, {5'b0, m_vec(1)});
         check("R3 control register vs model", ctl_rdata, m_ctl());
         check("R10 irq vs model", {7'b0, irq_o}, {7'b0, mi});
      end
   end

   task automatic idle();
      ctl_wr = 0; flag_wr = 0; tx_start = 0; tx_done = 0; soft_rst = 0;
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
      idle();
   endtask

   task automatic wctl(input logic [7:0] d);
      ctl_wr = 1; ctl_wdata = d; tick();
   endtask

   task automatic sched(input logic [2:0] d);
      flag_wr = 1; flag_wdata = d; tick();
   endtask

   task automatic start(input int i);
      tx_start = 1; tx_start_idx = 2'(i); tick();
   endtask

   task automatic done(input int i, input bit ok);
      tx_done = 1; tx_done_idx = 2'(i); tx_done_ok = ok; tick();
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      done_flag = 1;
      summary();
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      @(negedge clk); #1;
      check("R1 empty after reset", {5'b0, empty_o}, 8'h07);
      check("R1 ack after reset", {5'b0, ack_o}, 8'h00);
      check("R1 ctl after reset", ctl_rdata, 8'h00);
      check("R1 irq after reset", {7'b0, irq_o}, 8'h00);

      wctl(8'h8F); // reserved bits written 1
      check("R3 enables load, reserved read 0", ctl_rdata, 8'h07);
      check("R10 irq with all empty enabled", {7'b0, irq_o}, 8'h01);

      sched(3'b011);
      check("R2 schedule clears empty", {5'b0, empty_o}, 8'h04);
      sched(3'b011);
      check("R2 second schedule ignored", {5'b0, empty_o}, 8'h04);

      wctl(8'h47);
      check("R4 abort on empty buffer ignored", ctl_rdata, 8'h07);

      start(0);
      start(1);
      wctl(8'h17);
      check("R9 in-flight request pending", ctl_rdata, 8'h17);
      tick();
      check("R9 in-flight request waits", {5'b0, empty_o}, 8'h04);
      wctl(8'h07);
      check("R4 writing 0 does not clear", ctl_rdata, 8'h17);
      done(0, 0);
      check("R9 failed attempt grants abort empty", {5'b0, empty_o}, 8'h05);
      check("R9 failed attempt grants abort ack", {5'b0, ack_o}, 8'h01);
      check("R4 request cleared on empty", ctl_rdata, 8'h07);
      done(1, 1);
      check("R7 success sets empty", {5'b0, empty_o}, 8'h07);
      check("R7 success leaves ack 0", {5'b0, ack_o}, 8'h01);

      sched(3'b010);
      wctl(8'h27);
      check("R5 idle request posted", ctl_rdata, 8'h27);
      tick();
      check("R5 idle grant empty", {5'b0, empty_o}, 8'h07);
      check("R5 idle grant ack", {5'b0, ack_o}, 8'h03);

      sched(3'b100);
      wctl(8'h47);
      start(2); // same cycle as idle grant
      check("R6 grant wins over start", {5'b0, ack_o}, 8'h07);
      done(2, 1);
      check("R6 done after ignored start has no effect", {5'b0, ack_o}, 8'h07);

      sched(3'b001);
      check("R2 schedule clears ack", {5'b0, ack_o}, 8'h06);
      start(0);
      done(0, 0);
      check("R8 failure keeps buffer scheduled", {5'b0, empty_o}, 8'h06);
      start(0);
      done(0, 1);
      check("R8 retry accepted and completes", {5'b0, empty_o}, 8'h07);
      check("R8 retry leaves ack 0", {5'b0, ack_o}, 8'h06);

      sched(3'b100);
      wctl(8'h07);
      start(2);
      wctl(8'h47);
      soft_rst = 1; tick();
      check("R11 soft reset clears control", ctl_rdata, 8'h00);
      check("R11 flags unaffected", {5'b0, empty_o}, 8'h03);
      soft_rst = 1; ctl_wr = 1; ctl_wdata = 8'h07; tick();
      check("R11 writes ignored while held", ctl_rdata, 8'h00);
      check("R10 irq off with enables cleared", {7'b0, irq_o}, 8'h00);
      done(2, 1);

      for (int k = 0; k < 3000; k++) begin
         soft_rst     = ($urandom % 50) == 0;
         ctl_wr       = ($urandom % 6) == 0;
         ctl_wdata    = 8'($urandom);
         flag_wr      = ($urandom % 5) == 0;
         flag_wdata   = 3'($urandom);
         tx_start     = ($urandom % 4) == 0;
         tx_start_idx = 2'($urandom % 3);
         tx_done      = ($urandom % 4) == 0;
         tx_done_idx  = 2'($urandom % 3);
         tx_done_ok   = 1'($urandom);
         tick();
      end

      done_flag = 1;
      summary();
      $finish;
   end
endmodule